// File: doc/BRIEF.md
# First-fault gather byte load sequencer

This block carries out one vector gather load of signed bytes with first-fault semantics. On a start pulse it decodes a 32-bit instruction word. If the word is not one of the two accepted forms, it reports it as undefined and does nothing else. For an accepted word it captures the governing predicate, the base vector and the incoming first-fault mask. It then walks the element lanes in ascending order and issues one single-byte read per active lane on a valid/ready request port. Responses carry a data byte and a fault bit.

Only the first active lane may raise a real fault, and it does so through the abort output; no writeback is signalled in that case. Faults on later lanes are absorbed silently. From the faulting lane to the last lane the first-fault mask is cleared and the destination is forced to zero. A done pulse marks the cycle in which the new destination vector and the updated mask are valid. The vector length is a parameter. The predicate and the mask hold one bit per vector byte.

Top module: `ffgather_seq`

## Requirements
- R1: A start with an instruction word outside the two accepted forms produces a one-cycle undef pulse in the cycle after start, issues no request and gives no done or abort. Both forms have bits 22:21 = 01 and bits 15:13 = 101. The narrow form has bits 31:23 = 100001000 and the wide form has 110001000. Bits 12:0 have no effect.
- R2: The narrow form uses 32-bit elements (VL/32 lanes) and the wide form uses 64-bit elements (VL/64 lanes). Every memory read is one byte.
- R3: The read address of a lane is its base element, zero-extended to 64 bits, plus the unsigned 5-bit offset in bits 20:16. Carries reach bit 32 and above, and in the wide form the sum wraps modulo 2^64.
- R4: A lane is active when the predicate bit at position lane*(element bytes) is set; the other bits of its group are ignored. An inactive lane issues no read and writes zero to its destination element.
- R5: Lanes are serviced in ascending index order with at most one read outstanding. While a request waits for ready, its valid and address stay unchanged.
- R6: If the first active lane's read returns a fault, abort pulses for one cycle. No done follows, no further read is issued, and the block returns to idle.
- R7: A fault on any later active lane is suppressed. The mask group of that lane and of every higher lane is cleared to zero, and the read of each higher active lane is still issued. Mask bits are never set.
- R8: Loaded bytes are sign-extended to the element width.
- R9: Starting at the lowest lane whose mask element (the lowest bit of its group, after any clearing) is zero, that lane and every higher lane write zero to the destination.
- R10: After the last lane, done pulses for one cycle with dst_vec and ffr_out valid. With no active lane, no read is issued and done still follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (taken only when idle) |
| insn | input | 32 | Instruction word |
| pred | input | VL/8 | Governing predicate, one bit per byte |
| ffr_in | input | VL/8 | Incoming first-fault mask, one bit per byte |
| base_vec | input | VL | Base address vector |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Byte read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 8 | Read response byte |
| mem_rsp_fault | input | 1 | Read response fault flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse; outputs valid |
| abort | output | 1 | One-cycle first-lane fault pulse |
| undef | output | 1 | One-cycle undefined-encoding pulse |
| dst_vec | output | VL | New destination vector |
| ffr_out | output | VL/8 | Updated first-fault mask |

## Verification
The checker watches the request channel on every cycle. It checks that valid and address hold while ready is low, that no new request follows an accepted one before its response, and that no request appears while idle or with an undef pulse. It also checks that done and abort never coincide, that done is a single pulse, and that the mask at done is a subset of the mask captured at start. The values themselves can only be shown by the bench's scenarios: addresses and their order, sign extension, zeroing of inactive and unknown lanes, the lane at which mask clearing begins, and the split between a first-lane abort and a suppressed later fault.

// File: rtl/ffgather_seq.sv
module ffgather_seq #(
  parameter int VL = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     insn,
  input  logic [VL/8-1:0] pred,
  input  logic [VL/8-1:0] ffr_in,
  input  logic [VL-1:0]   base_vec,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [63:0]     mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [7:0]      mem_rsp_data,
  input  logic            mem_rsp_fault,
  output logic            busy,
  output logic            done,
  output logic            abort,
  output logic            undef,
  output logic [VL-1:0]   dst_vec,
  output logic [VL/8-1:0] ffr_out
);
  localparam int PL   = VL / 8;
  localparam int NL32 = VL / 32;
  localparam int NL64 = VL / 64;
  localparam int LW   = (NL32 > 1) ? $clog2(NL32) : 1;
  localparam int GW   = $clog2(PL);

  typedef enum logic [1:0] {S_IDLE, S_LANE, S_REQ, S_RSP} st_t;

  st_t           st;
  logic [LW-1:0] lane;
  logic          w64, first_r, flt_r, unk_r;
  logic [4:0]    imm;
  logic [PL-1:0] pred_r, ffr_r;
  logic [VL-1:0] base_r, res_r;
  logic [63:0]   addr_r;
  logic          done_r, abort_r, undef_r;

  wire is32  = insn[31:23] == 9'b100001000 && insn[22:21] == 2'b01 && insn[15:13] == 3'b101;
  wire is64  = insn[31:23] == 9'b110001000 && insn[22:21] == 2'b01 && insn[15:13] == 3'b101;
  wire legal = is32 | is64;
  logic unused_fields;
  assign unused_fields = ^insn[12:0];

  logic any_act;
  always_comb begin
    any_act = 1'b0;
    for (int i = 0; i < PL; i++)
      if (is64 ? (i % 8 == 0) : (i % 4 == 0)) any_act = any_act | pred[i];
  end

  logic [GW-1:0] gidx;
  logic [63:0]   elem_base;
  logic          lane_act, last;
  assign gidx      = GW'(int'(lane) * (w64 ? 8 : 4));
  assign lane_act  = pred_r[gidx];
  assign elem_base = w64 ? base_r[int'(lane)*64 +: 64] : {32'b0, base_r[int'(lane)*32 +: 32]};
  assign last      = w64 ? (lane == LW'(NL64 - 1)) : (lane == LW'(NL32 - 1));

  logic        lane_flt, flt_n, ffr_bit, unk_n, retire;
  logic [63:0] val;
  always_comb begin
    lane_flt = (st == S_RSP) && !first_r && mem_rsp_fault;
    flt_n    = flt_r | lane_flt;
    ffr_bit  = ffr_r[gidx] & ~flt_n;
    unk_n    = unk_r | ~ffr_bit;
    val      = '0;
    if (st == S_RSP && !unk_n) val = {{56{mem_rsp_data[7]}}, mem_rsp_data};
    retire   = (st == S_LANE && !lane_act) ||
               (st == S_RSP && mem_rsp_valid && !(first_r && mem_rsp_fault));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; lane <= '0; w64 <= 1'b0; imm <= '0;
      first_r <= 1'b0; flt_r <= 1'b0; unk_r <= 1'b0;
      pred_r <= '0; ffr_r <= '0; base_r <= '0; res_r <= '0; addr_r <= '0;
      done_r <= 1'b0; abort_r <= 1'b0; undef_r <= 1'b0;
    end else begin
      done_r <= 1'b0; abort_r <= 1'b0; undef_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!legal) undef_r <= 1'b1;
          else begin
            w64 <= is64; imm <= insn[20:16];
            pred_r <= pred; ffr_r <= ffr_in;
            if (any_act) base_r <= base_vec;
            res_r <= '0; lane <= '0;
            first_r <= 1'b1; flt_r <= 1'b0; unk_r <= 1'b0;
            st <= S_LANE;
          end
        end
        S_LANE: if (lane_act) begin
          addr_r <= elem_base + 64'(imm);
          st <= S_REQ;
        end
        S_REQ: if (mem_req_ready) st <= S_RSP;
        S_RSP: if (mem_rsp_valid) begin
          if (first_r && mem_rsp_fault) begin
            abort_r <= 1'b1;
            st <= S_IDLE;
          end
          first_r <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
      if (retire) begin
        flt_r <= flt_n;
        unk_r <= unk_n;
        if (w64) begin
          res_r[int'(lane)*64 +: 64] <= val;
          if (flt_n) ffr_r[gidx +: 8] <= '0;
        end else begin
          res_r[int'(lane)*32 +: 32] <= val[31:0];
          if (flt_n) ffr_r[gidx +: 4] <= '0;
        end
        if (last) begin
          done_r <= 1'b1;
          st <= S_IDLE;
        end else begin
          lane <= lane + LW'(1);
          st <= S_LANE;
        end
      end
    end
  end

  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = addr_r;
  assign busy          = (st != S_IDLE);
  assign done          = done_r;
  assign abort         = abort_r;
  assign undef         = undef_r;
  assign dst_vec       = res_r;
  assign ffr_out       = ffr_r;
endmodule

// File: rtl/ffgather_seq_chk.sv
module ffgather_seq_chk #(
  parameter int VL = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VL/8-1:0] ffr_in,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [63:0]     mem_req_addr,
  input logic            busy,
  input logic            done,
  input logic            abort,
  input logic            undef,
  input logic [VL/8-1:0] ffr_out
);
  logic [VL/8-1:0] ffr_snap;
  always_ff @(posedge clk) begin
    if (!rst_n) ffr_snap <= '0;
    else if (start && !busy) ffr_snap <= ffr_in;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid); // R10
  AST_UNDEF_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !busy && !mem_req_valid && !done && !abort); // R1
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !abort); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FFR_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ffr_out & ~ffr_snap) == '0); // R7
endmodule

bind ffgather_seq ffgather_seq_chk #(.VL(VL)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ffr_in(ffr_in),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .busy(busy), .done(done), .abort(abort),
  .undef(undef), .ffr_out(ffr_out)
);

// File: tb/ffgather_seq_tb_top.sv
module ffgather_seq_tb_top;
  localparam int VL = 128;
  localparam int PL = VL / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start = 1'b0;
  logic [31:0]   insn = '0;
  logic [PL-1:0] pred = '0, ffr_in = '0;
  logic [VL-1:0] base_vec = '0;
  logic          mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_fault;
  logic [63:0]   mem_req_addr;
  logic [7:0]    mem_rsp_data;
  logic          busy, done, abort, undef;
  logic [VL-1:0] dst_vec;
  logic [PL-1:0] ffr_out;

  ffgather_seq #(.VL(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .pred(pred),
    .ffr_in(ffr_in), .base_vec(base_vec), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_fault(mem_rsp_fault), .busy(busy), .done(done), .abort(abort),
    .undef(undef), .dst_vec(dst_vec), .ffr_out(ffr_out)
  );

  int checks = 0, fails = 0;
  int nreq = 0, stall = 0;
  logic        fault_en = 1'b0;
  logic [63:0] fault_addr = '0;
  logic [63:0] log_a [16];

  function automatic logic [7:0] mdat(logic [63:0] a);
    return a[7:0] + 8'h7B;
  endfunction

  function automatic logic [31:0] mk(bit wide, logic [4:0] off);
    return {wide ? 9'b110001000 : 9'b100001000, 2'b01, off, 3'b101, 13'h1A5B};
  endfunction

  task automatic chk(bit ok, string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_fault = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [63:0] a;
        repeat (stall) @(negedge clk);
        mem_req_ready = 1'b1;
        a = mem_req_addr;
        if (nreq < 16) log_a[nreq] = a;
        nreq++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mdat(a);
        mem_rsp_fault = fault_en && (a == fault_addr);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_fault = 1'b0;
      end
    end
  end

  task automatic run(string tag, logic [31:0] w, logic [PL-1:0] p, logic [PL-1:0] f,
                     logic [VL-1:0] b, bit fen, logic [63:0] fa, int stl);
    bit legal, wide, first, flt, unk;
    int nl, g, kind, ekind, ena;
    logic [63:0] ea [16];
    logic [VL-1:0] edst;
    logic [PL-1:0] effr;
    legal = w[22:21] == 2'b01 && w[15:13] == 3'b101 &&
            (w[31:23] == 9'b100001000 || w[31:23] == 9'b110001000);
    wide = w[30];
    nl = wide ? VL / 64 : VL / 32;
    g  = wide ? 8 : 4;
    first = 1; flt = 0; unk = 0; ena = 0; edst = '0; effr = f;
    ekind = legal ? 0 : 2;
    if (legal) begin
      for (int e = 0; e < nl; e++) begin
        bit act, lf;
        logic [63:0] a, v;
        logic [7:0] d;
        act = p[e*g];
        lf = 0; v = '0;
        if (act) begin
          a = wide ? b[e*64 +: 64] : {32'b0, b[e*32 +: 32]};
          a = a + 64'(w[20:16]);
          ea[ena] = a; ena++;
          d = mdat(a);
          if (first) begin
            if (fen && a == fa) begin ekind = 1; break; end
            first = 0;
          end else lf = fen && a == fa;
          v = {{56{d[7]}}, d};
        end
        flt = flt | lf;
        if (flt) for (int k = 0; k < g; k++) effr[e*g+k] = 1'b0;
        unk = unk | ~effr[e*g];
        if (unk || !act) v = '0;
        if (wide) edst[e*64 +: 64] = v; else edst[e*32 +: 32] = v[31:0];
      end
    end
    nreq = 0; stall = stl; fault_en = fen; fault_addr = fa;
    insn = w; pred = p; ffr_in = f; base_vec = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    kind = -1;
    for (int i = 0; i < 400; i++) begin
      if (done) begin kind = 0; break; end
      if (abort) begin kind = 1; break; end
      if (undef) begin kind = 2; break; end
      @(negedge clk);
    end
    chk(kind == ekind, {tag, " outcome"}, VL'(kind), VL'(ekind));
    if (kind == 0 && ekind == 0) begin
      chk(dst_vec === edst, {tag, " dst"}, dst_vec, edst);
      chk(ffr_out === effr, {tag, " ffr"}, VL'(ffr_out), VL'(effr));
    end
    repeat (8) @(negedge clk);
    chk(nreq == ena, {tag, " R5 request count"}, VL'(nreq), VL'(ena));
    for (int i = 0; i < ena && i < nreq; i++)
      chk(log_a[i] === ea[i], {tag, " R3 R5 address order"}, VL'(log_a[i]), VL'(ea[i]));
    chk(!busy, {tag, " idle after"}, VL'(busy), '0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !abort && !undef && !mem_req_valid, "reset R10 idle",
        VL'({busy, done, abort, undef, mem_req_valid}), '0);
    chk(dst_vec == '0 && ffr_out == '0, "reset outputs", dst_vec, '0);
  endtask

  task automatic t_all32;
    run("all32 R2 R8", mk(0, 5'd5), '1, '1,
        {32'h0000_4010, 32'h0000_30F0, 32'h0000_2004, 32'h0000_1010}, 0, '0, 0);
  endtask

  task automatic t_wide;
    run("wide64 R2 R3 R8", mk(1, 5'd31), 16'h0101, '1,
        {64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0001_0000_0040}, 0, '0, 0);
  endtask

  task automatic t_partial;
    run("partial R4 R3 stall R5", mk(0, 5'd31), 16'h1012, '1,
        {32'h0000_5005, 32'h0000_6006, 32'hFFFF_FFF0, 32'h0000_7007}, 0, '0, 3);
  endtask

  task automatic t_none;
    run("none R10 R4", mk(0, 5'd3), 16'hEEEE, 16'hFFFF,
        {4{32'h0000_0100}}, 0, '0, 0);
  endtask

  task automatic t_first_fault;
    run("first fault R6", mk(1, 5'd2), '1, '1,
        {64'h0000_0000_0000_0200, 64'h0000_0000_0000_0100}, 1, 64'h102, 0);
    run("first fault lane1 R6", mk(0, 5'd0), 16'h0010, '1,
        {32'h0000_0400, 32'h0000_0300, 32'h0000_0200, 32'h0000_0100}, 1, 64'h200, 0);
  endtask

  task automatic t_later_fault;
    run("later fault R7 R9", mk(0, 5'd1), '1, '1,
        {32'h0000_0480, 32'h0000_0380, 32'h0000_0280, 32'h0000_0180}, 1, 64'h281, 0);
    run("later fault wide R7", mk(1, 5'd0), '1, '1,
        {64'h0000_0000_0000_0A90, 64'h0000_0000_0000_0B10}, 1, 64'hA90, 1);
  endtask

  task automatic t_ffr_hole;
    run("ffr hole R9", mk(0, 5'd4), '1, 16'hFF0F,
        {32'h0000_0010, 32'h0000_0020, 32'h0000_0090, 32'h0000_00A0}, 0, '0, 0);
  endtask

  task automatic t_undef;
    run("undef R1 bits15_13", {9'b100001000, 2'b01, 5'd3, 3'b100, 13'h0}, '1, '1, '0, 0, '0, 0);
    run("undef R1 bits22_21", {9'b100001000, 2'b00, 5'd3, 3'b101, 13'h0}, '1, '1, '0, 0, '0, 0);
    run("undef R1 bits31_23", {9'b100001001, 2'b01, 5'd3, 3'b101, 13'h0}, '1, '1, '0, 0, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_all32;
    t_wide;
    t_partial;
    t_none;
    t_first_fault;
    t_all32;
    t_later_fault;
    t_ffr_hole;
    t_undef;
    t_all32;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule